// File: doc/BRIEF.md
# Bit-Level Pipelined Adder

This block adds two unsigned 16-bit operands in a pipeline that is cut at bit level. One operand pair may enter on every clock, and the 17-bit sum, with the carry out as its top bit, leaves exactly eight clocks later. The datapath is split into 2-bit lanes. Each pipeline stage holds one lane's slice of a triangular half-adder array, so the carry moves across two bit positions per clock.

Operand slices for higher lanes are held back by input skew registers. As a result, each lane meets the carry that the lane below it produced one clock earlier. The lane sums then pass through deskew registers, so that all seventeen bits arrive in the same cycle. A valid flag travels alongside the data through the same number of register stages.

The block fits where a wide adder would otherwise limit the clock rate, for example in the accumulation tree of a filter that has pipelined multipliers.

Top module: `bitpipe_adder`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `out_vld` is 0 and `sum_o` is 0.
- R2: When `out_vld` is 1, `sum_o` equals the unsigned sum of the operands that came with the matching `in_vld`. `sum_o[16]` is the carry out.
- R3: The sum and its valid flag appear exactly 8 clock edges after the operands are sampled. If nothing valid has been sampled in the previous 8 edges, `out_vld` is 0.
- R4: A new operand pair is accepted on every clock. Results of back-to-back pairs do not disturb each other, even when a carry is still rippling.
- R5: A carry that starts at bit 0 ripples through all 16 positions: 0xFFFF + 0x0001 gives 0x10000, and 0x00FF + 0x0001 gives 0x00100.
- R6: A cycle with `in_vld` = 0 produces `out_vld` = 0 eight cycles later, whatever operands are presented.
- R7: The largest sum, 0xFFFF + 0xFFFF, gives 0x1FFFE. Whenever bit 16 is set, the low 16 bits are never all ones.
- R8: Asserting reset discards every operand pair in flight. After release, `out_vld` stays 0 until new valid operands have had 8 cycles to pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operands on `op_a`/`op_b` are valid this cycle |
| op_a | input | 16 | First operand, unsigned |
| op_b | input | 16 | Second operand, unsigned |
| out_vld | output | 1 | `sum_o` holds a valid result |
| sum_o | output | 17 | Registered sum, carry out in bit 16 |

## Verification
The case that needs care is a long carry travelling up through the lanes while a new operand pair enters the lanes behind it in the very next cycle. Each lane then carries one lane's slice of the earlier sum and another lane's slice of the later sum at once. This is provoked by issuing all-ones plus one, a zero pair, an alternating pattern whose carry runs the full width, and the maximum pair, all back to back. Each result is judged on its own output cycle against an unsigned sum computed in the bench, and idle cycles are checked to have a low valid flag.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  // one half-adder cell: {carry, sum}
  function automatic logic [1:0] half_add(input logic x, input logic y);
    return {x & y, x ^ y};
  endfunction
endpackage

// File: rtl/delay_line.sv
module delay_line #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stage_q [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= d;
          for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/pair_cell.sv
module pair_cell
  import bpa_pkg::*;
#(
  parameter int LANE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic              cin,
  output logic [LANE_W-1:0] s_q,
  output logic              cout_q
);
  logic [LANE_W:0]   c;
  logic [LANE_W-1:0] s_d;

  assign c[0] = cin;

  // two rows of half adders per bit; the rows of all bits in the lane share a stage
  generate
    for (genvar i = 0; i < LANE_W; i++) begin : g_bit
      logic [1:0] row0, row1;
      assign row0     = half_add(a[i], b[i]);
      assign row1     = half_add(row0[0], c[i]);
      assign s_d[i]   = row1[0];
      assign c[i+1]   = row0[1] | row1[1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      s_q    <= '0;
      cout_q <= 1'b0;
    end else begin
      s_q    <= s_d;
      cout_q <= c[LANE_W];
    end
  end

  logic [LANE_W:0] lane_ref;
  assign lane_ref = {1'b0, a} + {1'b0, b} + {{LANE_W{1'b0}}, cin};

  // R5: each lane passes the carry on correctly to the next lane
  assert_lane_carry_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> {cout_q, s_q} == $past(lane_ref));
endmodule

// File: rtl/bitpipe_adder.sv
module bitpipe_adder #(
  parameter int WIDTH  = 16,
  parameter int LANE_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             out_vld,
  output logic [WIDTH:0]   sum_o
);
  localparam int LANES = WIDTH / LANE_W;
  localparam int LAT   = LANES;

  logic [LANES-1:0] carry_q;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [2*LANE_W-1:0] skew_q;
      logic [LANE_W-1:0]   cell_s;
      logic [LANE_W-1:0]   out_s;
      logic                cin_k;

      // input skew: lane k waits k cycles for the carry from below
      delay_line #(.W(2*LANE_W), .DEPTH(k)) u_skew (
        .clk(clk), .rst(rst),
        .d({op_a[k*LANE_W +: LANE_W], op_b[k*LANE_W +: LANE_W]}),
        .q(skew_q)
      );

      if (k == 0) begin : g_c0
        assign cin_k = 1'b0;
      end else begin : g_cn
        assign cin_k = carry_q[k-1];
      end

      pair_cell #(.LANE_W(LANE_W)) u_cell (
        .clk(clk), .rst(rst),
        .a(skew_q[2*LANE_W-1:LANE_W]),
        .b(skew_q[LANE_W-1:0]),
        .cin(cin_k),
        .s_q(cell_s),
        .cout_q(carry_q[k])
      );

      // output deskew: realign lane k with the top lane
      delay_line #(.W(LANE_W), .DEPTH(LANES-1-k)) u_deskew (
        .clk(clk), .rst(rst), .d(cell_s), .q(out_s)
      );

      assign sum_o[k*LANE_W +: LANE_W] = out_s;
    end
  endgenerate

  assign sum_o[WIDTH] = carry_q[LANES-1];

  delay_line #(.W(1), .DEPTH(LAT)) u_vld (
    .clk(clk), .rst(rst), .d(in_vld), .q(out_vld)
  );

  // checking window: behavioural sum shifted LAT cycles
  logic [WIDTH:0] chk_sum [LAT];
  logic [LAT-1:0] chk_vld;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_vld <= '0;
      for (int i = 0; i < LAT; i++) chk_sum[i] <= '0;
    end else begin
      chk_vld    <= {chk_vld[LAT-2:0], in_vld};
      chk_sum[0] <= {1'b0, op_a} + {1'b0, op_b};
      for (int i = 1; i < LAT; i++) chk_sum[i] <= chk_sum[i-1];
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_vld && sum_o == '0));

  assert_sum_match_R2: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> sum_o == chk_sum[LAT-1]);

  assert_vld_latency_R3: assert property (@(posedge clk) disable iff (rst)
    out_vld == chk_vld[LAT-1]);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    sum_o[WIDTH] |-> sum_o[WIDTH-1:0] != '1);
endmodule

// File: tb/tb_bitpipe_adder.sv
module tb_bitpipe_adder;
  localparam int W   = 16;
  localparam int LAT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic out_vld;
  logic [W:0] sum_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [W-1:0] qa [64];
  logic [W-1:0] qb [64];
  bit           qv [64];

  always #2 clk = ~clk;

  bitpipe_adder #(.WIDTH(W), .LANE_W(2)) dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .out_vld(out_vld), .sum_o(sum_o)
  );

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // issue n items back to back, then drain; check each output cycle
  task automatic run_burst(input string req, input int n);
    for (int j = 0; j < n + LAT; j++) begin
      @(negedge clk);
      if (j < LAT) begin
        check({req, " R3 idle"}, {16'h0, out_vld}, 17'h0);
      end else if (qv[j-LAT]) begin
        check({req, " R3 vld"}, {16'h0, out_vld}, 17'h1);
        check({req, " R2 sum"}, sum_o, {1'b0, qa[j-LAT]} + {1'b0, qb[j-LAT]});
      end else begin
        check({req, " R6 gap"}, {16'h0, out_vld}, 17'h0);
      end
      if (j < n) begin
        in_vld = qv[j]; op_a = qa[j]; op_b = qb[j];
      end else begin
        in_vld = 1'b0; op_a = 16'hA5A5; op_b = 16'h5A5A;
      end
    end
  endtask

  task automatic put(input int i, input logic [W-1:0] a, input logic [W-1:0] b, input bit v);
    qa[i] = a; qb[i] = b; qv[i] = v;
  endtask

  task automatic t_reset();
    rst = 1'b1; in_vld = 1'b1; op_a = 16'hFFFF; op_b = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R1 vld in reset", {16'h0, out_vld}, 17'h0);
    check("R1 sum in reset", sum_o, 17'h0);
    in_vld = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 vld after release", {16'h0, out_vld}, 17'h0);
    check("R1 sum after release", sum_o, 17'h0);
    repeat (LAT) @(negedge clk);
  endtask

  task automatic t_basic();
    put(0, 16'h0001, 16'h0002, 1);
    put(1, 16'h1234, 16'h4321, 1);
    put(2, 16'h0000, 16'h0000, 1);
    put(3, 16'h8000, 16'h8000, 1);
    put(4, 16'h7FFF, 16'h0001, 1);
    run_burst("R2 basic", 5);
  endtask

  task automatic t_carry_mix();
    // R4/R5: long carries interleaved with idle-carry pairs
    put(0, 16'hFFFF, 16'h0001, 1);
    put(1, 16'h0000, 16'h0000, 1);
    put(2, 16'h00FF, 16'h0001, 1);
    put(3, 16'h5555, 16'hAAAB, 1);
    put(4, 16'hFFFF, 16'hFFFF, 1);
    put(5, 16'h0001, 16'h0000, 1);
    put(6, 16'hFFFE, 16'h0001, 1);
    put(7, 16'h0F0F, 16'hF0F1, 1);
    run_burst("R4 R5 carry", 8);
  endtask

  task automatic t_max();
    put(0, 16'hFFFF, 16'hFFFF, 1);
    run_burst("R7 max", 1);
  endtask

  task automatic t_gaps();
    for (int i = 0; i < 12; i++)
      put(i, 16'(i * 16'h1357), 16'(16'hFFFF - i * 16'h0F0F), (i % 3) != 1);
    run_burst("R6 gaps", 12);
  endtask

  task automatic t_flush();
    // R8: fill pipe, reset mid-stream, expect nothing to emerge
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      in_vld = 1'b1; op_a = 16'(i + 1); op_b = 16'hFFFF;
    end
    @(negedge clk);
    in_vld = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int j = 0; j < LAT + 2; j++) begin
      @(negedge clk);
      check("R8 flushed vld", {16'h0, out_vld}, 17'h0);
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_carry_mix();
    t_max();
    t_gaps();
    t_flush();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule